// File: doc/BRIEF.md
# Trap Vector and Privilege Router

This block sits beside a processor's trap sequencer and answers two questions for every trap that is taken: which handler table receives it, and at what address the handler starts. From the current privilege bits, the current trap depth, the trap's number and a per-trap code saying which privilege level should service it, the router picks one of four outcomes. A trap can go to the fixed recovery vector, to the supervisor table, to the hypervisor table, or it can be refused because the trap stack is already full. It then forms the handler PC and the following NPC. Saving the interrupted state is done elsewhere; this block only routes and computes addresses.

A request is presented for one cycle on `trap_req`. Exactly one cycle later the registered result appears with `vec_valid` high. A power-on request on `por_req` takes priority. It produces a recovery-vector dispatch with trap number 1, together with the reset values of trap depth, global level and the six mode flags that the state unit loads. Once a full trap stack refuses a trap, the overflow flag stays high until reset.

Top module: `trap_router`

## Requirements
- R1: The current mode is hypervisor when `cur_hpriv` is 1, else supervisor when `cur_priv` is 1, else user. `tgt_code` 0 selects supervisor service. Code 1 selects hypervisor service, except that in user mode it selects supervisor service. Codes 2 and 3 select hypervisor service.
- R2: When `cur_red` is 1 or `trap_lvl` equals MAX_TL-1, the route is recovery (code 2), the effective trap number is 5 and the PC is 0xFFF0000000 OR ((5<<5) & 0xFF) = 0xFFF00000A0.
- R3: When neither R2 condition holds and `trap_lvl` equals MAX_TL, the route is overflow (code 3), the effective trap number is the input trap number, PC and NPC are 0, and `err_flag` rises and stays 1 until reset.
- R4: Otherwise, when `trap_lvl` exceeds MAX_PTL and the selected service level is supervisor, the route is hypervisor (code 1) with effective trap number 2.
- R5: Otherwise the route is hypervisor (code 1) with the input trap number when the service level is hypervisor, or when it is supervisor and the trap number is 384 or more. All other traps take the supervisor route (code 0) with the input trap number.
- R6: A hypervisor PC is `hyp_base` with bits 13:0 cleared, OR (trap number << 5) masked to 14 bits.
- R7: A supervisor PC is `sup_base` with bits 14:0 cleared, OR bit 14 when `trap_lvl`+1 exceeds 1, OR (trap number << 5) masked to 14 bits.
- R8: For every route other than overflow, NPC equals PC plus 4.
- R9: A power-on request gives the recovery route with trap number 1 and PC 0xFFF0000020. It raises `por_load` with `rst_tl` = MAX_TL, `rst_gl` = MAX_GL and `rst_flags` = 6'b111100, whose bits from MSB to LSB are fp-enable, supervisor, recovery, hypervisor, break-enable and trap-level-zero-watch. These reset outputs are 0 whenever `por_load` is 0.
- R10: Results appear one cycle after the request with `vec_valid` 1. `vec_valid` is 0 in any cycle that follows a cycle without a request.
- R11: After reset, `vec_valid`, `por_load`, `err_flag`, `vec_route`, `vec_tt`, `vec_pc` and `vec_npc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | One-cycle trap dispatch request |
| por_req | input | 1 | Power-on reset dispatch request, wins over trap_req |
| cur_hpriv | input | 1 | Current hypervisor bit |
| cur_priv | input | 1 | Current supervisor bit |
| cur_red | input | 1 | Current recovery-state bit |
| trap_lvl | input | TLW | Current trap depth |
| trap_num | input | 9 | Trap number |
| tgt_code | input | 2 | Service level code for this trap in the current mode |
| sup_base | input | ADDRW | Supervisor table base |
| hyp_base | input | ADDRW | Hypervisor table base |
| vec_valid | output | 1 | Result valid |
| vec_route | output | 2 | 0 supervisor, 1 hypervisor, 2 recovery, 3 overflow |
| vec_tt | output | 9 | Effective trap number |
| vec_pc | output | ADDRW | Handler PC |
| vec_npc | output | ADDRW | Handler NPC |
| err_flag | output | 1 | Sticky trap-stack overflow |
| por_load | output | 1 | Reset values below are valid |
| rst_tl | output | TLW | Trap depth to load on power-on |
| rst_gl | output | GLW | Global level to load on power-on |
| rst_flags | output | 6 | Mode flags to load on power-on |

## Verification
The hardest case to reach is the redirect of R4. It needs a trap depth above the supervisor limit but below the recovery threshold, a clear recovery bit, and a service code that resolves to supervisor. In user mode that code may be split or plain supervisor. The bench sweeps every trap depth from 0 to MAX_TL against all eight combinations of the privilege bits and all four service codes, under a set of trap numbers that straddle 384. The depths 3 and 4 therefore meet every mode and code pairing. The overflow row comes last in each depth sweep. Before a reset, the bench confirms that the flag stays high across later legal traps.

// File: rtl/trap_router_pkg.sv
package trap_router_pkg;

  localparam int TTW = 9;

  typedef enum logic [1:0] {
    RT_SUP = 2'd0,
    RT_HYP = 2'd1,
    RT_RCV = 2'd2,
    RT_OVF = 2'd3
  } route_t;

  typedef enum logic [1:0] {
    MD_USER = 2'd0,
    MD_SUP  = 2'd1,
    MD_HYP  = 2'd2
  } mode_t;

  localparam logic [63:0]    RCV_BASE   = 64'h0000_00FF_F000_0000;
  localparam logic [TTW-1:0] TT_RCV     = 9'd5;
  localparam logic [TTW-1:0] TT_GUARD   = 9'd2;
  localparam logic [TTW-1:0] TT_POWERUP = 9'd1;
  localparam logic [TTW-1:0] TT_HYP_MIN = 9'd384;

  // Trap number scaled to its 32-byte slot, kept inside 14 bits.
  function automatic logic [63:0] slot_off(input logic [TTW-1:0] tt);
    return 64'({tt, 5'b00000}) & 64'h3FFF;
  endfunction

  function automatic logic [63:0] rcv_vec(input logic [TTW-1:0] tt);
    return RCV_BASE | (slot_off(tt) & 64'h00FF);
  endfunction

  function automatic logic [63:0] hyp_vec(input logic [63:0] base,
                                          input logic [TTW-1:0] tt);
    return (base & ~64'h3FFF) | slot_off(tt);
  endfunction

  function automatic logic [63:0] sup_vec(input logic [63:0] base,
                                          input logic [TTW-1:0] tt,
                                          input logic nested);
    return (base & ~64'h7FFF) | (nested ? 64'h4000 : 64'h0) | slot_off(tt);
  endfunction

endpackage

// File: rtl/trap_route_decide.sv
module trap_route_decide
  import trap_router_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TLW     = 3
) (
  input  logic           hpriv,
  input  logic           priv,
  input  logic           red,
  input  logic [TLW-1:0] tl,
  input  logic [TTW-1:0] tt,
  input  logic [1:0]     tgt,
  output mode_t          cur_mode,
  output mode_t          svc_level,
  output route_t         route,
  output logic [TTW-1:0] eff_tt,
  output logic           nested
);

  localparam logic [TLW-1:0] TL_RCV = TLW'(MAX_TL - 1);
  localparam logic [TLW-1:0] TL_TOP = TLW'(MAX_TL);
  localparam logic [TLW-1:0] TL_PTL = TLW'(MAX_PTL);

  logic rcv_hit, ovf_hit, guard_hit, hyp_hit;

  always_comb begin
    if (hpriv)     cur_mode = MD_HYP;
    else if (priv) cur_mode = MD_SUP;
    else           cur_mode = MD_USER;
  end

  always_comb begin
    unique case (tgt)
      2'd0:    svc_level = MD_SUP;
      2'd1:    svc_level = (cur_mode == MD_USER) ? MD_SUP : MD_HYP;
      default: svc_level = MD_HYP;
    endcase
  end

  assign rcv_hit   = red || (tl == TL_RCV);
  assign ovf_hit   = (tl == TL_TOP);
  assign guard_hit = (tl > TL_PTL) && (svc_level == MD_SUP);
  assign hyp_hit   = (svc_level == MD_HYP) || (tt >= TT_HYP_MIN);
  assign nested    = (tl != '0);

  always_comb begin
    route  = RT_SUP;
    eff_tt = tt;
    if (rcv_hit) begin
      route  = RT_RCV;
      eff_tt = TT_RCV;
    end else if (ovf_hit) begin
      route  = RT_OVF;
    end else if (guard_hit) begin
      route  = RT_HYP;
      eff_tt = TT_GUARD;
    end else if (hyp_hit) begin
      route  = RT_HYP;
    end
  end

  // R1: hypervisor bit dominates the supervisor bit
  always_comb begin
    if (hpriv) a_r1_mode_prio: assert (cur_mode == MD_HYP);
  end

endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_router_pkg::*;
#(
  parameter int ADDRW = 64
) (
  input  route_t           route,
  input  logic [TTW-1:0]   tt,
  input  logic             nested,
  input  logic [ADDRW-1:0] sup_base,
  input  logic [ADDRW-1:0] hyp_base,
  output logic [ADDRW-1:0] pc,
  output logic [ADDRW-1:0] npc
);

  localparam int           INSN_BYTES = 4;
  localparam logic [63:0]  ZERO64     = 64'd0;

  logic [63:0] pc_wide;

  always_comb begin
    unique case (route)
      RT_RCV:  pc_wide = rcv_vec(tt);
      RT_HYP:  pc_wide = hyp_vec(64'(hyp_base), tt);
      RT_SUP:  pc_wide = sup_vec(64'(sup_base), tt, nested);
      default: pc_wide = ZERO64;
    endcase
  end

  assign pc  = ADDRW'(pc_wide);
  assign npc = (route == RT_OVF) ? '0 : pc + ADDRW'(INSN_BYTES);

endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_router_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int ADDRW   = 64,
  parameter int TLW     = $clog2(MAX_TL + 1),
  parameter int GLW     = $clog2(MAX_GL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic             por_req,
  input  logic             cur_hpriv,
  input  logic             cur_priv,
  input  logic             cur_red,
  input  logic [TLW-1:0]   trap_lvl,
  input  logic [8:0]       trap_num,
  input  logic [1:0]       tgt_code,
  input  logic [ADDRW-1:0] sup_base,
  input  logic [ADDRW-1:0] hyp_base,
  output logic             vec_valid,
  output logic [1:0]       vec_route,
  output logic [8:0]       vec_tt,
  output logic [ADDRW-1:0] vec_pc,
  output logic [ADDRW-1:0] vec_npc,
  output logic             err_flag,
  output logic             por_load,
  output logic [TLW-1:0]   rst_tl,
  output logic [GLW-1:0]   rst_gl,
  output logic [5:0]       rst_flags
);

  // {fp_en, sup, recovery, hyp, brk_en, tl0_watch}
  localparam logic [5:0] POR_FLAGS = 6'b111100;

  mode_t            cur_mode, svc_level;
  route_t           dec_route, sel_route;
  logic [TTW-1:0]   dec_tt, sel_tt;
  logic             dec_nested;
  logic [ADDRW-1:0] nxt_pc, nxt_npc;
  logic             take_trap, ovf_event;

  trap_route_decide #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TLW(TLW)) u_decide (
    .hpriv     (cur_hpriv),
    .priv      (cur_priv),
    .red       (cur_red),
    .tl        (trap_lvl),
    .tt        (trap_num),
    .tgt       (tgt_code),
    .cur_mode  (cur_mode),
    .svc_level (svc_level),
    .route     (dec_route),
    .eff_tt    (dec_tt),
    .nested    (dec_nested)
  );

  assign sel_route = por_req ? RT_RCV : dec_route;
  assign sel_tt    = por_req ? TT_POWERUP : dec_tt;
  assign take_trap = trap_req && !por_req;
  assign ovf_event = take_trap && (dec_route == RT_OVF);

  trap_vec_gen #(.ADDRW(ADDRW)) u_vec (
    .route    (sel_route),
    .tt       (sel_tt),
    .nested   (dec_nested),
    .sup_base (sup_base),
    .hyp_base (hyp_base),
    .pc       (nxt_pc),
    .npc      (nxt_npc)
  );

  logic   valid_q, por_q, err_q;
  route_t route_q;
  logic [TTW-1:0]   tt_q;
  logic [ADDRW-1:0] pc_q, npc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      por_q   <= 1'b0;
      err_q   <= 1'b0;
      route_q <= RT_SUP;
      tt_q    <= '0;
      pc_q    <= '0;
      npc_q   <= '0;
    end else begin
      valid_q <= trap_req || por_req;
      por_q   <= por_req;
      err_q   <= err_q || ovf_event;
      if (trap_req || por_req) begin
        route_q <= sel_route;
        tt_q    <= sel_tt;
        pc_q    <= nxt_pc;
        npc_q   <= nxt_npc;
      end
    end
  end

  assign vec_valid = valid_q;
  assign vec_route = route_q;
  assign vec_tt    = tt_q;
  assign vec_pc    = pc_q;
  assign vec_npc   = npc_q;
  assign err_flag  = err_q;
  assign por_load  = por_q;
  assign rst_tl    = por_q ? TLW'(MAX_TL) : '0;
  assign rst_gl    = por_q ? GLW'(MAX_GL) : '0;
  assign rst_flags = por_q ? POR_FLAGS : '0;

  a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || por_req) |=> vec_valid);
  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !por_req) |=> !vec_valid);
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r3_ovf_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_route == RT_OVF) |-> err_flag);
  a_r8_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_route != RT_OVF) |-> (vec_npc == vec_pc + ADDRW'(4)));
  a_r2_rcv_base: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_route == RT_RCV) |-> (64'(vec_pc) & ~64'hFF) == RCV_BASE);
  a_r9_por_route: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> (por_load && vec_route == RT_RCV && vec_tt == TT_POWERUP));
  a_r6_hyp_slot_align: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_route == RT_HYP) |-> vec_pc[4:0] == 5'd0);

endmodule

// File: tb/tb_trap_router.sv
`timescale 1ns/1ps
module tb_trap_router;

  localparam int MAX_TL = 6, MAX_PTL = 2, MAX_GL = 3, ADDRW = 64;
  localparam int TLW = 3, GLW = 2;

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, por_req = 0, cur_hpriv = 0, cur_priv = 0, cur_red = 0;
  logic [TLW-1:0] trap_lvl = '0;
  logic [8:0] trap_num = '0;
  logic [1:0] tgt_code = '0;
  logic [ADDRW-1:0] sup_base = '0, hyp_base = '0;
  logic vec_valid, err_flag, por_load;
  logic [1:0] vec_route;
  logic [8:0] vec_tt;
  logic [ADDRW-1:0] vec_pc, vec_npc;
  logic [TLW-1:0] rst_tl;
  logic [GLW-1:0] rst_gl;
  logic [5:0] rst_flags;

  int n_checks = 0, n_fail = 0;
  bit exp_err = 0;

  always #4 clk = ~clk;

  trap_router #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .MAX_GL(MAX_GL), .ADDRW(ADDRW)) dut (
    .clk, .rst_n, .trap_req, .por_req, .cur_hpriv, .cur_priv, .cur_red,
    .trap_lvl, .trap_num, .tgt_code, .sup_base, .hyp_base,
    .vec_valid, .vec_route, .vec_tt, .vec_pc, .vec_npc, .err_flag,
    .por_load, .rst_tl, .rst_gl, .rst_flags);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic run_trap(input bit h, input bit p, input bit r, input int tl,
                          input int tgt, input int tt, input logic [63:0] sb,
                          input logic [63:0] hb);
    int user_mode, svc_sup, e_route, e_tt;
    logic [63:0] e_pc, e_npc;
    user_mode = (!h && !p) ? 1 : 0;
    svc_sup   = (tgt == 0 || (tgt == 1 && user_mode == 1)) ? 1 : 0;
    e_tt = tt;
    if (r || tl == MAX_TL - 1) begin
      e_route = 2; e_tt = 5;                      // R2
    end else if (tl == MAX_TL) begin
      e_route = 3;                                // R3
    end else if (tl > MAX_PTL && svc_sup == 1) begin
      e_route = 1; e_tt = 2;                      // R4
    end else if (svc_sup == 0 || tt >= 384) begin
      e_route = 1;                                // R5
    end else begin
      e_route = 0;                                // R1 / R5
    end
    case (e_route)
      0: e_pc = (sb / 64'h8000) * 64'h8000 + ((tl + 1 > 1) ? 64'h4000 : 0)
                + 64'(e_tt * 32);                 // R7
      1: e_pc = (hb / 64'h4000) * 64'h4000 + 64'(e_tt * 32);   // R6
      2: e_pc = 64'hFF_F000_0000 + 64'((e_tt * 32) % 256);
      default: e_pc = 0;
    endcase
    e_npc = (e_route == 3) ? 64'd0 : e_pc + 4;    // R8
    if (e_route == 3) exp_err = 1;
    @(negedge clk);
    cur_hpriv = h; cur_priv = p; cur_red = r; trap_lvl = TLW'(tl);
    tgt_code = 2'(tgt); trap_num = 9'(tt); sup_base = sb; hyp_base = hb;
    trap_req = 1;
    @(negedge clk);
    trap_req = 0;
    check(vec_valid == 1'b1, "R10 valid", 64'(vec_valid), 1);
    check(vec_route == 2'(e_route), "R1/R2/R3/R4/R5 route", 64'(vec_route), 64'(e_route));
    check(vec_tt == 9'(e_tt), "R2/R4/R5 trap number", 64'(vec_tt), 64'(e_tt));
    check(vec_pc == e_pc, "R2/R6/R7 pc", vec_pc, e_pc);
    check(vec_npc == e_npc, "R8 npc", vec_npc, e_npc);
    check(err_flag == exp_err, "R3 err_flag", 64'(err_flag), 64'(exp_err));
  endtask

  int tts [8] = '{0, 5, 36, 127, 256, 383, 384, 511};

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    check(vec_valid == 0 && por_load == 0 && err_flag == 0, "R11 reset flags",
          {61'd0, vec_valid, por_load, err_flag}, 0);
    check(vec_route == 0 && vec_tt == 0 && vec_pc == 0 && vec_npc == 0, "R11 reset data",
          vec_pc, 0);
    rst_n = 1;
    @(negedge clk);
    // R9 power-on dispatch (trap_req also high: por wins)
    por_req = 1; trap_req = 1; trap_lvl = 3'd6;
    @(negedge clk);
    por_req = 0; trap_req = 0;
    check(por_load == 1 && vec_valid == 1, "R9 por_load", 64'(por_load), 1);
    check(vec_route == 2 && vec_tt == 1, "R9 route/tt", {vec_route, vec_tt}, {2'd2, 9'd1});
    check(vec_pc == 64'hFF_F000_0020, "R9 pc", vec_pc, 64'hFF_F000_0020);
    check(rst_tl == 3'd6 && rst_gl == 2'd3, "R9 rst_tl/gl", {rst_tl, rst_gl}, {3'd6, 2'd3});
    check(rst_flags == 6'b111100, "R9 rst_flags", 64'(rst_flags), 64'b111100);
    check(err_flag == 0, "R3 por no err", 64'(err_flag), 0);
    @(negedge clk);
    // R10 / R9 idle cycle
    check(vec_valid == 0 && por_load == 0, "R10 idle", {vec_valid, por_load}, 0);
    check(rst_tl == 0 && rst_gl == 0 && rst_flags == 0, "R9 rst outputs idle",
          {rst_tl, rst_gl, rst_flags}, 0);

    // Sweep: depth x privilege bits x service code x trap numbers
    for (int tl = 0; tl <= MAX_TL; tl++)
      for (int m = 0; m < 8; m++)
        for (int tg = 0; tg < 4; tg++)
          for (int k = 0; k < 8; k++)
            run_trap(m[2], m[1], m[0], tl, tg, tts[k],
                     (k % 2) ? 64'hFFFF_8000_1234_FFFF : 64'h0000_0012_3456_7ABC,
                     (k % 2) ? 64'h0000_0ABC_DEF0_3FFF : 64'hFFFF_FFFF_FFFF_C123);

    // R3 sticky across a later legal trap, then cleared by reset
    run_trap(0, 1, 0, 0, 0, 16, 64'h8000, 64'hC000);
    check(err_flag == 1, "R3 sticky", 64'(err_flag), 1);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(err_flag == 0 && vec_valid == 0, "R11 reset clears err", 64'(err_flag), 0);
    rst_n = 1; exp_err = 0;
    run_trap(0, 0, 0, 1, 1, 300, 64'h0, 64'h0);
    @(negedge clk);
    check(vec_valid == 0, "R10 valid drops", 64'(vec_valid), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule